// File: doc/BRIEF.md
# Byte FIFO Pair with Occupancy Watermark Interrupts

This block sits between a word-wide memory-mapped register port and a serial shift engine. It holds two byte queues. The transmit queue is filled by register writes and drained by the engine through a valid/ready pop handshake. The receive queue is filled by the engine through a valid/ready push handshake and drained by register reads.

Each direction has a single data register. That register carries both the byte and a status flag in bit 31. Two programmable occupancy thresholds produce two pending levels. An enable register selects which of these levels reach one interrupt line.

Software that is streaming out data programs a transmit threshold and waits for the transmit pending bit. Software that expects N returned bytes writes N-1 to the receive threshold and waits for the receive pending bit.

Top module: `spi_wm_fifo_pair`

## Requirements
- R1: After synchronous active-high reset, both queues are empty, the enable register reads 0, the transmit threshold reads 1 and the receive threshold reads 0, so the pending register reads 1.
- R2: A write to word index 0 (transmit data) pushes wdata[7:0] into the transmit queue. The engine sees the bytes in write order on `tx_pop_data`, with `tx_pop_valid` high while the queue is not empty, and one byte is removed per cycle with valid and ready both high.
- R3: A write to transmit data while the transmit queue holds DEPTH bytes is dropped and leaves the queue contents unchanged.
- R4: A read of word index 0 returns the transmit-full flag in bit 31 and zero in all other bits.
- R5: A read of word index 1 (receive data) returns the head byte in bits 7:0 and the receive-empty flag in bit 31, with other bits zero. Asserting `reg_rd` on it pops one entry only when the queue is not empty.
- R6: The engine's push is taken when `rx_push_ready` is high, which is whenever the receive queue is not full. A push while the queue is full is dropped.
- R7: Pending bit 0 (transmit) is high exactly when the transmit occupancy is below the transmit threshold (word index 2, bits CW-1:0).
- R8: Pending bit 1 (receive) is high exactly when the receive occupancy is above the receive threshold (word index 3, bits CW-1:0). A threshold of N-1 raises it once N bytes have arrived.
- R9: The enable register (word index 4) uses the pending layout: bit 0 is transmit and bit 1 is receive. `irq` is the OR of the pending bits ANDed with their enables.
- R10: The pending register (word index 5) is read-only. Writes to it and to receive data change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tx_pop_valid | output | 1 | Transmit byte available to the engine |
| tx_pop_ready | input | 1 | Engine takes the transmit byte |
| tx_pop_data | output | 8 | Transmit head byte |
| rx_push_valid | input | 1 | Engine offers a received byte |
| rx_push_ready | output | 1 | Receive queue can accept a byte |
| rx_push_data | input | 8 | Received byte |
| irq | output | 1 | Enabled pending interrupt |

## Verification
The hardest situations to reach are the boundaries of both queues. One is a transmit write arriving while the queue is exactly full and the engine is stalled. The other is a receive read arriving while the queue is exactly empty. Each is followed by traffic that would reveal a corrupted pointer.

The stimulus holds the engine handshakes idle while it fills the transmit queue to DEPTH through the register port and the receive queue to DEPTH through the push side. It then issues the extra write, push or read, drains each queue against a reference queue, and confirms that the stray byte never appears.

The thresholds are moved to occupancy points one below and one at the crossing, so each pending bit is seen on both sides of its edge.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int FLAG_BIT = 31;

    typedef enum logic [2:0] {
        RA_TXD   = 3'd0,
        RA_RXD   = 3'd1,
        RA_TXWM  = 3'd2,
        RA_RXWM  = 3'd3,
        RA_IEN   = 3'd4,
        RA_IPEND = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic rx_wm;
        logic tx_wm;
    } wm_bits_t;

    function automatic logic [WORD_W-1:0] data_word(input logic flag,
                                                    input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FLAG_BIT] = flag;
        w[BYTE_W-1:0] = b;
        return w;
    endfunction

endpackage

// File: rtl/wm_byte_fifo.sv
module wm_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wm_irq_gen.sv
module wm_irq_gen
    import spi_wm_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_mark,
    input  logic [CW-1:0] rx_mark,
    input  wm_bits_t      ien,
    output wm_bits_t      ipend,
    output logic          irq
);
    always_comb begin
        ipend.tx_wm = (tx_count < tx_mark);
        ipend.rx_wm = (rx_count > rx_mark);
        irq = |(ipend & ien);
    end
endmodule

// File: rtl/spi_wm_fifo_pair.sv
module spi_wm_fifo_pair
    import spi_wm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_pop_valid,
    input  logic              tx_pop_ready,
    output logic [BYTE_W-1:0] tx_pop_data,
    input  logic              rx_push_valid,
    output logic              rx_push_ready,
    input  logic [BYTE_W-1:0] rx_push_data,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     tx_cnt, rx_cnt, tx_mark, rx_mark;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_head;
    wm_bits_t          ien, ipend;
    logic              wr_txd, rd_rxd;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_txd = reg_wr && (reg_addr == RA_TXD);
    assign rd_rxd = reg_rd && (reg_addr == RA_RXD);

    wm_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) tx_q (
        .clk(clk), .rst(rst),
        .push(wr_txd), .push_data(reg_wdata[BYTE_W-1:0]),
        .pop(tx_pop_ready),
        .head(tx_pop_data), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    wm_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) rx_q (
        .clk(clk), .rst(rst),
        .push(rx_push_valid), .push_data(rx_push_data),
        .pop(rd_rxd),
        .head(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    assign tx_pop_valid  = !tx_empty;
    assign rx_push_ready = !rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mark <= CW'(1);
            rx_mark <= '0;
            ien     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_TXWM: tx_mark <= reg_wdata[CW-1:0];
                RA_RXWM: rx_mark <= reg_wdata[CW-1:0];
                RA_IEN:  ien     <= wm_bits_t'(reg_wdata[1:0]);
                default: ;
            endcase
        end
    end

    wm_irq_gen #(.CW(CW)) irq_i (
        .tx_count(tx_cnt), .rx_count(rx_cnt),
        .tx_mark(tx_mark), .rx_mark(rx_mark),
        .ien(ien), .ipend(ipend), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_TXD:   reg_rdata = data_word(tx_full, '0);
            RA_RXD:   reg_rdata = data_word(rx_empty, rx_empty ? '0 : rx_head);
            RA_TXWM:  reg_rdata[CW-1:0] = tx_mark;
            RA_RXWM:  reg_rdata[CW-1:0] = rx_mark;
            RA_IEN:   reg_rdata[1:0] = ien;
            RA_IPEND: reg_rdata[1:0] = ipend;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_wm_fifo_checker.sv
module spi_wm_fifo_checker
    import spi_wm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          tx_pop_valid,
    input logic          tx_pop_ready,
    input logic          rx_push_valid,
    input logic          rx_push_ready,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    ien
);
    logic c_wr_txd, c_rd_rxd;
    assign c_wr_txd = reg_wr && (reg_addr == RA_TXD);
    assign c_rd_rxd = reg_rd && (reg_addr == RA_RXD);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt == CW'(DEPTH) && c_wr_txd && !tx_pop_ready) |=> (tx_cnt == CW'(DEPTH))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == '0 && c_rd_rxd && !rx_push_valid) |=> (rx_cnt == '0)); // R5
    AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == CW'(DEPTH)) |-> !rx_push_ready); // R6
    AST_RX_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rx_push_valid && rx_push_ready && !c_rd_rxd) |=> (rx_cnt == $past(rx_cnt) + 1'b1)); // R6
    AST_TX_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_pop_valid |-> (tx_cnt != '0)); // R2
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq); // R9
endmodule

bind spi_wm_fifo_pair spi_wm_fifo_checker #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .tx_pop_valid(tx_pop_valid), .tx_pop_ready(tx_pop_ready),
    .rx_push_valid(rx_push_valid), .rx_push_ready(rx_push_ready), .irq(irq),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ien(ien)
);

// File: tb/spi_wm_fifo_pair_tb_top.sv
module spi_wm_fifo_pair_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop_valid, tx_pop_ready = 1'b0;
    logic [7:0]  tx_pop_data;
    logic        rx_push_valid = 1'b0, rx_push_ready;
    logic [7:0]  rx_push_data = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    spi_wm_fifo_pair #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop_valid(tx_pop_valid), .tx_pop_ready(tx_pop_ready), .tx_pop_data(tx_pop_data),
        .rx_push_valid(rx_push_valid), .rx_push_ready(rx_push_ready),
        .rx_push_data(rx_push_data), .irq(irq)
    );

    // vector: {kind[1:0], addr[2:0], wdata[31:0], expect[31:0]}; kind 0 = write, 1 = read and compare
    localparam int NV = 16;
    localparam logic [68:0] VEC [NV] = '{
        {2'd1, 3'd5, 32'h0,   32'h1},          // R1 pending after reset
        {2'd1, 3'd4, 32'h0,   32'h0},          // R1 enable reset
        {2'd1, 3'd2, 32'h0,   32'h1},          // R1 tx threshold
        {2'd1, 3'd3, 32'h0,   32'h0},          // R1 rx threshold
        {2'd0, 3'd0, 32'h1A5, 32'h0},          // R2 push A5
        {2'd1, 3'd5, 32'h0,   32'h0},          // R7 1 < 1 false
        {2'd0, 3'd2, 32'h3,   32'h0},
        {2'd1, 3'd5, 32'h0,   32'h1},          // R7 1 < 3
        {2'd0, 3'd0, 32'h3C,  32'h0},
        {2'd1, 3'd5, 32'h0,   32'h1},          // R7 2 < 3
        {2'd0, 3'd0, 32'h5A,  32'h0},
        {2'd1, 3'd5, 32'h0,   32'h0},          // R7 3 < 3 false
        {2'd1, 3'd0, 32'h0,   32'h0},          // R4 not full
        {2'd0, 3'd1, 32'h77,  32'h0},          // R10 write to rx data
        {2'd0, 3'd5, 32'h3,   32'h0},          // R10 write to pending
        {2'd1, 3'd5, 32'h0,   32'h0}           // R10 pending unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic pop,
                      input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a; reg_rd = pop;
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        rx_push_data = b; rx_push_valid = 1'b1;
        if (rx_push_ready) rxq.push_back(b);
        @(negedge clk);
        rx_push_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 tx_pop_valid", {31'b0, tx_pop_valid}, 32'h0);
        check("R6 rx_push_ready", {31'b0, rx_push_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][68:67] == 2'd0) begin
                wr(VEC[i][66:64], VEC[i][63:32]);
                if (VEC[i][66:64] == 3'd0) txq.push_back(VEC[i][39:32]);
            end else begin
                rd("R1/R4/R7/R10 table", VEC[i][66:64], 1'b0, VEC[i][31:0]);
            end
        end
        rd("R5 R10 rx empty read", 3'd1, 1'b1, 32'h8000_0000);

        // fill transmit queue to full
        for (int i = 0; i < 5; i++) begin
            wr(3'd0, 32'h10 + i);
            txq.push_back(8'h10 + 8'(i));
        end
        rd("R4 full flag", 3'd0, 1'b0, 32'h8000_0000);
        wr(3'd0, 32'hEE);                     // R3 dropped
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            @(negedge clk);
            e = txq.pop_front();
            check("R2 tx valid", {31'b0, tx_pop_valid}, 32'h1);
            check("R2 R3 tx order", {24'b0, tx_pop_data}, {24'b0, e});
            tx_pop_ready = 1'b1;
            @(negedge clk);
            tx_pop_ready = 1'b0;
        end
        #1;
        check("R3 overflow byte absent", {31'b0, tx_pop_valid}, 32'h0);
        rd("R7 empty below threshold", 3'd5, 1'b0, 32'h1);

        // receive watermark
        wr(3'd3, 32'h2);
        eng_push(8'h61);
        eng_push(8'h62);
        rd("R8 two bytes, threshold 2", 3'd5, 1'b0, 32'h1);
        eng_push(8'h63);
        rd("R8 three bytes", 3'd5, 1'b0, 32'h3);
        wr(3'd2, 32'h0);
        rd("R7 threshold 0", 3'd5, 1'b0, 32'h2);
        wr(3'd4, 32'h1);
        #1; check("R9 tx-only enable", {31'b0, irq}, 32'h0);
        wr(3'd4, 32'h2);
        #1; check("R9 rx enable", {31'b0, irq}, 32'h1);
        rd("R9 enable readback", 3'd4, 1'b0, 32'h2);

        // fill receive queue, overflow push
        for (int i = 0; i < 5; i++) eng_push(8'h70 + 8'(i));
        #1; check("R6 ready low when full", {31'b0, rx_push_ready}, 32'h0);
        eng_push(8'hDD);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            e = rxq.pop_front();
            rd("R5 R6 rx data order", 3'd1, 1'b1, {24'b0, e});
        end
        rd("R5 empty after drain", 3'd1, 1'b1, 32'h8000_0000);
        eng_push(8'h99);
        rd("R5 after underflow attempt", 3'd1, 1'b1, 32'h0000_0099);

        // reset mid-run
        wr(3'd0, 32'h44);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1; check("R1 tx empty after reset", {31'b0, tx_pop_valid}, 32'h0);
        rd("R1 enable cleared", 3'd4, 1'b0, 32'h0);
        rd("R1 tx threshold default", 3'd2, 1'b0, 32'h1);
        rd("R1 rx threshold default", 3'd3, 1'b0, 32'h0);
        rd("R1 pending default", 3'd5, 1'b0, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule